// File: doc/BRIEF.md
# Multi-Level Page Table Walker with Translation Cache

This block turns a virtual address into a physical address. A virtual address has two parts: the virtual page number (VPN) in the upper bits and the byte offset within the page in the lower bits. The offset goes into the physical address unchanged. The page number is translated through a tree of page tables held in memory. A small fully-associative translation cache sits in front of the walker. When it holds the page, the block answers at once and reads no memory.

When the cache misses, the walker splits the VPN into equal slices, one for each level, and uses the most significant slice first. At each level it issues one read of a page-table entry (PTE). The entry's address is the table base plus the slice index times the entry size. The first table base is a root physical page number given on an input. Every later base is the page number taken from the previous entry, shifted left by the offset width to make a byte address. The page number in the last-level entry, placed above the offset, forms the result. An entry whose valid bit is clear ends the walk with a fault. A walk that succeeds writes its mapping into the cache, and cache slots are replaced in round-robin order.

Requests use a ready/valid pair and are accepted only while the block is idle. Memory reads go out one at a time as single-cycle strobes. The memory answers later with a one-cycle data-valid strobe.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1 and `resp_valid` and `mem_rd_en` are 0.
- R2: The page offset is the low log2(PAGE_BYTES) bits of the virtual address. A successful response has `resp_paddr` = {final PPN, offset}, with the offset copied unchanged, including offsets 0 and PAGE_BYTES-1.
- R3: The VPN is cut into LEVELS equal slices and level j uses slice j, counted from the most significant end. The read address at level j is (base_ppn << log2(PAGE_BYTES)) + slice_j * PTE_BYTES, and the level-0 base is `ptbr_ppn`. A walk issues at most LEVELS reads.
- R4: In a PTE, bit 0 is the valid bit and bits [PPN_W:1] hold the PPN. At a non-final level that PPN is the base of the next table. A successful walk reads exactly LEVELS entries.
- R5: A PTE with bit 0 clear at any level ends the walk: the response has `resp_fault`=1 and `resp_paddr`=0, and no further reads are issued. A fault always follows at least one read.
- R6: On a cache hit, `resp_valid` rises in the second cycle after the accepting edge and no memory read is made, even if the tables in memory have changed since the cache was filled.
- R7: Only a successful walk fills the cache, and it fills it only on a miss. A faulting address walks again each time it is requested. At most one cache entry matches any VPN.
- R8: Fills go to the slots in round-robin order, starting at slot 0 after reset. After TLB_ENTRIES more distinct fills, the oldest mapping is evicted and misses again.
- R9: `mem_rd_en` is a one-cycle strobe, with at most one read outstanding. If the memory answers `lat` cycles after the strobe (lat >= 1), each level read adds lat+2 cycles, so the response comes 1 + reads*(lat+2) cycles after the accepting edge. `resp_valid` is a one-cycle pulse, and `req_ready` is 0 from acceptance until the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_ready | output | 1 | Block is idle and accepts a request |
| ptbr_ppn | input | PPN_W | Physical page number of the first-level table |
| mem_rd_en | output | 1 | PTE read strobe |
| mem_rd_addr | output | PPN_W+log2(PAGE_BYTES) | Byte address of the PTE to read |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 8*PTE_BYTES | PTE returned by memory |
| resp_valid | output | 1 | Translation result strobe |
| resp_paddr | output | PPN_W+log2(PAGE_BYTES) | Physical address, 0 on a fault |
| resp_fault | output | 1 | Walk met an invalid PTE |

## Verification
The assertions check the following on every cycle:
- read and response strobes last one cycle;
- a response never comes after more than LEVELS reads;
- a successful walk has made either zero or exactly LEVELS reads;
- a fault always follows a read;
- the cache never matches twice;
- the cache is filled only after a miss.

Other behaviour can only be shown by the bench's scenarios. These include the exact address arithmetic at each level and the offset passing through at its extremes. They also include a hit returning a stale mapping after memory has changed, faults at the first and last level that are not cached, round-robin eviction across five distinct pages, and response timing under several memory latencies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_TLB_CHECK,
      WS_ISSUE_READ,
      WS_WAIT_DATA,
      WS_NEXT_LEVEL,
      WS_DONE,
      WS_FAULT
   } walk_state_e;

   // width of an index into N items, never zero
   function automatic int safe_clog2(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ptw_tlb.sv
module ptw_tlb #(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 16,
   parameter int PPN_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn
);
   import ptw_pkg::*;

   localparam int PTR_W = safe_clog2(ENTRIES);

   logic [ENTRIES-1:0] ent_v;
   logic [ENTRIES-1:0] match;
   logic [VPN_W-1:0]   ent_vpn [ENTRIES];
   logic [PPN_W-1:0]   ent_ppn [ENTRIES];
   logic [PTR_W-1:0]   rr_ptr;
   logic [PTR_W-1:0]   rr_next;

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
         assign match[e] = ent_v[e] && (ent_vpn[e] == lk_vpn);
      end
   endgenerate

   assign lk_hit = |match;

   always_comb begin
      lk_ppn = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match[e]) lk_ppn = lk_ppn | ent_ppn[e];
      end
   end

   generate
      if (ENTRIES > 1) begin : g_rr
         assign rr_next = (rr_ptr == PTR_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end else begin : g_single
         assign rr_next = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_v  <= '0;
         rr_ptr <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            ent_vpn[e] <= '0;
            ent_ppn[e] <= '0;
         end
      end else if (fill_en) begin
         ent_v[rr_ptr]   <= 1'b1;
         ent_vpn[rr_ptr] <= fill_vpn;
         ent_ppn[rr_ptr] <= fill_ppn;
         rr_ptr          <= rr_next;
      end
   end

   AST_TLB_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R7
   AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> !lk_hit); // R7

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int VPN_W     = 16,
   parameter int LEVELS    = 2,
   parameter int OFF_W     = 10,
   parameter int PPN_W     = 12,
   parameter int PTE_BYTES = 4,
   parameter int LVL_W     = 1
) (
   input  logic [VPN_W-1:0]       vpn,
   input  logic [LVL_W-1:0]       level,
   input  logic [PPN_W-1:0]       base_ppn,
   output logic [PPN_W+OFF_W-1:0] pte_addr
);
   localparam int IDX_W  = VPN_W / LEVELS;
   localparam int PA_W   = PPN_W + OFF_W;
   localparam int PTE_SH = $clog2(PTE_BYTES);

   logic [IDX_W-1:0] slice_arr [LEVELS];
   logic [IDX_W-1:0] idx_sel;

   // slice 0 is the most significant part of the page number
   generate
      for (genvar l = 0; l < LEVELS; l++) begin : g_slice
         assign slice_arr[l] = vpn[VPN_W-1-l*IDX_W -: IDX_W];
      end
   endgenerate

   always_comb begin
      idx_sel = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (level == LVL_W'(l)) idx_sel = slice_arr[l];
      end
   end

   assign pte_addr = {base_ppn, {OFF_W{1'b0}}} + (PA_W'(idx_sel) << PTE_SH);

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm #(
   parameter int LEVELS = 2,
   parameter int PPN_W  = 12,
   parameter int PTE_W  = 32,
   parameter int LVL_W  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   output logic             accept,
   input  logic [PPN_W-1:0] ptbr_ppn,
   input  logic             tlb_hit,
   input  logic [PPN_W-1:0] tlb_ppn,
   output logic             mem_rd_en,
   input  logic             mem_rd_valid,
   input  logic [PTE_W-1:0] mem_rd_data,
   output logic [LVL_W-1:0] level,
   output logic [PPN_W-1:0] base_ppn,
   output logic             fill_en,
   output logic [PPN_W-1:0] fill_ppn,
   output logic             resp_valid,
   output logic             resp_fault,
   output logic [PPN_W-1:0] res_ppn
);
   import ptw_pkg::*;

   localparam int RC_W = $clog2(LEVELS + 1) + 1;

   walk_state_e      state;
   logic [PTE_W-1:0] pte_q;
   logic             pte_ok;
   logic [PPN_W-1:0] pte_ppn;
   logic             last_lvl;
   logic [RC_W-1:0]  rd_cnt;

   assign pte_ok   = pte_q[0];
   assign pte_ppn  = pte_q[PPN_W:1];
   assign last_lvl = (level == LVL_W'(LEVELS - 1));

   generate
      if (PTE_W > PPN_W + 1) begin : g_spare
         logic unused_pte_hi;
         assign unused_pte_hi = ^pte_q[PTE_W-1:PPN_W+1];
      end
   endgenerate

   assign req_ready  = (state == WS_IDLE);
   assign accept     = req_ready && req_valid;
   assign mem_rd_en  = (state == WS_ISSUE_READ);
   assign fill_en    = (state == WS_NEXT_LEVEL) && pte_ok && last_lvl;
   assign fill_ppn   = pte_ppn;
   assign resp_valid = (state == WS_DONE) || (state == WS_FAULT);
   assign resp_fault = (state == WS_FAULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= WS_IDLE;
         level    <= '0;
         base_ppn <= '0;
         pte_q    <= '0;
         res_ppn  <= '0;
         rd_cnt   <= '0;
      end else begin
         case (state)
            WS_IDLE: begin
               if (req_valid) begin
                  state  <= WS_TLB_CHECK;
                  rd_cnt <= '0;
               end
            end
            WS_TLB_CHECK: begin
               if (tlb_hit) begin
                  res_ppn <= tlb_ppn;
                  state   <= WS_DONE;
               end else begin
                  level    <= '0;
                  base_ppn <= ptbr_ppn;
                  state    <= WS_ISSUE_READ;
               end
            end
            WS_ISSUE_READ: begin
               rd_cnt <= rd_cnt + 1'b1;
               state  <= WS_WAIT_DATA;
            end
            WS_WAIT_DATA: begin
               if (mem_rd_valid) begin
                  pte_q <= mem_rd_data;
                  state <= WS_NEXT_LEVEL;
               end
            end
            WS_NEXT_LEVEL: begin
               if (!pte_ok) begin
                  state <= WS_FAULT;
               end else if (last_lvl) begin
                  res_ppn <= pte_ppn;
                  state   <= WS_DONE;
               end else begin
                  base_ppn <= pte_ppn;
                  level    <= level + 1'b1;
                  state    <= WS_ISSUE_READ;
               end
            end
            WS_DONE:  state <= WS_IDLE;
            WS_FAULT: state <= WS_IDLE;
            default:  state <= WS_IDLE;
         endcase
      end
   end

   AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en); // R9
   AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> (!resp_valid && req_ready)); // R9
   AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (rd_cnt <= RC_W'(LEVELS))); // R3
   AST_FAULT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_fault) |-> (rd_cnt != '0)); // R5
   AST_FULL_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_fault && rd_cnt != '0) |-> (rd_cnt == RC_W'(LEVELS))); // R4

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int VA_W        = 26,
   parameter int PAGE_BYTES  = 1024,
   parameter int LEVELS      = 2,
   parameter int PTE_BYTES   = 4,
   parameter int PPN_W       = 12,
   parameter int TLB_ENTRIES = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   input  logic [VA_W-1:0]                        req_vaddr,
   output logic                                   req_ready,
   input  logic [PPN_W-1:0]                       ptbr_ppn,
   output logic                                   mem_rd_en,
   output logic [PPN_W+$clog2(PAGE_BYTES)-1:0]    mem_rd_addr,
   input  logic                                   mem_rd_valid,
   input  logic [8*PTE_BYTES-1:0]                 mem_rd_data,
   output logic                                   resp_valid,
   output logic [PPN_W+$clog2(PAGE_BYTES)-1:0]    resp_paddr,
   output logic                                   resp_fault
);
   import ptw_pkg::*;

   localparam int OFF_W = $clog2(PAGE_BYTES);
   localparam int VPN_W = VA_W - OFF_W;
   localparam int IDX_W = VPN_W / LEVELS;
   localparam int PA_W  = PPN_W + OFF_W;
   localparam int PTE_W = 8 * PTE_BYTES;
   localparam int LVL_W = safe_clog2(LEVELS);

   generate
      if ((1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if ((1 << $clog2(PTE_BYTES)) != PTE_BYTES) begin : g_bad_pte
         $error("PTE_BYTES must be a power of two");
      end
      if (LEVELS < 1 || VPN_W < LEVELS || (VPN_W % LEVELS) != 0) begin : g_bad_split
         $error("page number bits must divide evenly among LEVELS");
      end
      if (IDX_W + $clog2(PTE_BYTES) > OFF_W) begin : g_bad_table
         $error("one table level must fit inside a single page");
      end
      if (PPN_W + 1 > PTE_W) begin : g_bad_ppn
         $error("PTE too narrow for valid bit and page number");
      end
      if (TLB_ENTRIES < 1) begin : g_bad_tlb
         $error("TLB_ENTRIES must be at least one");
      end
   endgenerate

   logic [VA_W-1:0]  vaddr_q;
   logic [VPN_W-1:0] vpn;
   logic [OFF_W-1:0] offset;
   logic             accept;
   logic             tlb_hit;
   logic [PPN_W-1:0] tlb_ppn;
   logic [LVL_W-1:0] level;
   logic [PPN_W-1:0] base_ppn;
   logic             fill_en;
   logic [PPN_W-1:0] fill_ppn;
   logic [PPN_W-1:0] res_ppn;

   assign vpn    = vaddr_q[VA_W-1:OFF_W];
   assign offset = vaddr_q[OFF_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vaddr_q <= '0;
      else if (accept) vaddr_q <= req_vaddr;
   end

   ptw_tlb #(
      .ENTRIES (TLB_ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W)
   ) u_tlb (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_vpn   (vpn),
      .lk_hit   (tlb_hit),
      .lk_ppn   (tlb_ppn),
      .fill_en  (fill_en),
      .fill_vpn (vpn),
      .fill_ppn (fill_ppn)
   );

   ptw_addr_gen #(
      .VPN_W     (VPN_W),
      .LEVELS    (LEVELS),
      .OFF_W     (OFF_W),
      .PPN_W     (PPN_W),
      .PTE_BYTES (PTE_BYTES),
      .LVL_W     (LVL_W)
   ) u_addr (
      .vpn      (vpn),
      .level    (level),
      .base_ppn (base_ppn),
      .pte_addr (mem_rd_addr)
   );

   ptw_fsm #(
      .LEVELS (LEVELS),
      .PPN_W  (PPN_W),
      .PTE_W  (PTE_W),
      .LVL_W  (LVL_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .accept       (accept),
      .ptbr_ppn     (ptbr_ppn),
      .tlb_hit      (tlb_hit),
      .tlb_ppn      (tlb_ppn),
      .mem_rd_en    (mem_rd_en),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_data  (mem_rd_data),
      .level        (level),
      .base_ppn     (base_ppn),
      .fill_en      (fill_en),
      .fill_ppn     (fill_ppn),
      .resp_valid   (resp_valid),
      .resp_fault   (resp_fault),
      .res_ppn      (res_ppn)
   );

   assign resp_paddr = (resp_valid && !resp_fault) ? {res_ppn, offset} : '0;

   AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_rd_en); // R9

endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;

   localparam int VA_W = 26, PAGE_BYTES = 1024, LEVELS = 2, PTE_BYTES = 4;
   localparam int PPN_W = 12, TLB_N = 4;
   localparam int OFF_W = 10, VPN_W = 16, IDX_W = 8, PA_W = 22, PTE_W = 32;
   localparam int unsigned ROOT = 12'h010;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [VA_W-1:0]  req_vaddr = '0;
   logic             req_ready;
   logic [PPN_W-1:0] ptbr_ppn = PPN_W'(ROOT);
   logic             mem_rd_en;
   logic [PA_W-1:0]  mem_rd_addr;
   logic             mem_rd_valid = 1'b0;
   logic [PTE_W-1:0] mem_rd_data = '0;
   logic             resp_valid;
   logic [PA_W-1:0]  resp_paddr;
   logic             resp_fault;

   always #5 clk = ~clk;

   pt_walker #(
      .VA_W(VA_W), .PAGE_BYTES(PAGE_BYTES), .LEVELS(LEVELS),
      .PTE_BYTES(PTE_BYTES), .PPN_W(PPN_W), .TLB_ENTRIES(TLB_N)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_ready(req_ready), .ptbr_ppn(ptbr_ppn), .mem_rd_en(mem_rd_en),
      .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
      .mem_rd_data(mem_rd_data), .resp_valid(resp_valid),
      .resp_paddr(resp_paddr), .resp_fault(resp_fault)
   );

   int n_checks = 0;
   int n_err    = 0;
   bit finished = 0;

   // memory image and behavioural translation-cache model
   int unsigned mem_img [int unsigned];
   int unsigned m_vpn [TLB_N];
   int unsigned m_ppn [TLB_N];
   bit          m_v   [TLB_N];
   int          m_rr = 0;
   int          cur_lat = 1;

   task automatic chk(string rq, string what, longint unsigned act, longint unsigned exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic int unsigned mem_rd(int unsigned a);
      if (mem_img.exists(a)) return mem_img[a];
      return 0;
   endfunction

   task automatic set_pte(int unsigned tbl, int unsigned idx, int unsigned ppn, bit v);
      mem_img[(tbl << OFF_W) + idx * PTE_BYTES] = (ppn << 1) | 32'(v);
   endtask

   function automatic int unsigned mk_va(int unsigned i0, int unsigned i1, int unsigned off);
      return (i0 << (IDX_W + OFF_W)) | (i1 << OFF_W) | off;
   endfunction

   // memory responder: answers cur_lat cycles after a read strobe
   initial begin
      int unsigned pend_addr = 0;
      int          wait_cnt  = 0;
      forever begin
         @(negedge clk);
         mem_rd_valid = 1'b0;
         if (wait_cnt > 0) begin
            wait_cnt--;
            if (wait_cnt == 0) begin
               mem_rd_valid = 1'b1;
               mem_rd_data  = mem_rd(pend_addr);
            end
         end
         if (mem_rd_en) begin
            pend_addr = 32'(mem_rd_addr);
            wait_cnt  = cur_lat;
         end
      end
   end

   task automatic translate(int unsigned va, int lat, string rq);
      int unsigned exp_q [$];
      int unsigned vpn, off, ppn, base, pte, idx;
      bit          hit, fault;
      int          slot, nrd, exp_k, k;
      longint unsigned exp_pa;
      vpn = va >> OFF_W;
      off = va & (PAGE_BYTES - 1);
      hit = 0; fault = 0; ppn = 0;
      for (int e = 0; e < TLB_N; e++) begin
         if (m_v[e] && m_vpn[e] == vpn) begin hit = 1; ppn = m_ppn[e]; end
      end
      if (!hit) begin
         base = ROOT;
         for (int j = 0; j < LEVELS; j++) begin
            if (!fault) begin
               idx = (vpn >> ((LEVELS - 1 - j) * IDX_W)) & ((1 << IDX_W) - 1);
               exp_q.push_back((base << OFF_W) + idx * PTE_BYTES);
               pte = mem_rd((base << OFF_W) + idx * PTE_BYTES);
               if ((pte & 1) == 0) fault = 1;
               else base = (pte >> 1) & ((1 << PPN_W) - 1);
            end
         end
         if (!fault) begin
            ppn = base;
            slot = m_rr;
            m_v[slot] = 1; m_vpn[slot] = vpn; m_ppn[slot] = ppn;
            m_rr = (m_rr + 1) % TLB_N;
         end
      end
      nrd    = exp_q.size();
      exp_k  = 1 + nrd * (lat + 2);
      exp_pa = fault ? 0 : ((longint'(ppn) << OFF_W) | off);
      cur_lat = lat;

      @(negedge clk);
      chk("R9", {rq, " ready before request"}, req_ready, 1);
      req_valid = 1'b1;
      req_vaddr = VA_W'(va);
      @(negedge clk);
      req_valid = 1'b0;
      k = 0;
      while (1) begin
         if (mem_rd_en) begin
            if (exp_q.size() == 0) chk(hit ? "R6" : "R5", {rq, " unexpected read"}, 1, 0);
            else chk("R3", {rq, " PTE address"}, mem_rd_addr, exp_q.pop_front());
         end
         if (resp_valid) begin
            chk("R9", {rq, " response cycle"}, k, exp_k);
            chk("R5", {rq, " fault flag"}, resp_fault, fault);
            chk("R2", {rq, " physical address"}, resp_paddr, exp_pa);
            break;
         end
         if (k > 200) begin
            chk("R9", {rq, " response timeout"}, k, exp_k);
            break;
         end
         chk("R9", {rq, " busy while walking"}, req_ready, 0);
         k++;
         @(negedge clk);
      end
      chk(hit ? "R6" : "R4", {rq, " all reads issued"}, exp_q.size(), 0);
      @(negedge clk);
      chk("R9", {rq, " response pulse ends"}, {resp_valid, req_ready}, 2'b01);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL R9 watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      for (int e = 0; e < TLB_N; e++) m_v[e] = 0;
      // page tables: root 0x010; second-level tables 0x020 and 0x021
      set_pte(ROOT, 8'h12, 12'h020, 1);
      set_pte(ROOT, 8'h13, 12'h021, 1);
      set_pte(ROOT, 8'hFF, 12'h022, 1);
      set_pte(12'h020, 8'h34, 12'hABC, 1);
      set_pte(12'h020, 8'h35, 12'h201, 1);
      set_pte(12'h020, 8'h36, 12'h204, 1);
      set_pte(12'h020, 8'h77, 12'h3FF, 0);
      set_pte(12'h021, 8'h00, 12'h202, 1);
      set_pte(12'h021, 8'hFF, 12'h203, 1);
      set_pte(12'h022, 8'hFF, 12'hFFF, 1);

      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1", "ready in reset", req_ready, 1);
      chk("R1", "resp in reset", resp_valid, 0);
      chk("R1", "read in reset", mem_rd_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "idle after reset", {req_ready, resp_valid, mem_rd_en}, 3'b100);

      // R3 R4: full two-level miss
      translate(mk_va(8'h12, 8'h34, 10'h155), 1, "R4 miss A");
      // R6 R2: hit with top offset, then offset zero
      translate(mk_va(8'h12, 8'h34, 10'h3FF), 3, "R6 hit A top offset");
      translate(mk_va(8'h12, 8'h34, 10'h000), 2, "R2 hit A zero offset");
      // R6: memory changed, hit must still return the cached mapping
      set_pte(12'h020, 8'h34, 12'h111, 1);
      translate(mk_va(8'h12, 8'h34, 10'h0AA), 1, "R6 stale hit A");
      // R5: fault at level 0 and at the final level
      translate(mk_va(8'h55, 8'h00, 10'h010), 1, "R5 fault level0");
      translate(mk_va(8'h12, 8'h77, 10'h020), 2, "R5 fault level1");
      // R7: the faulting page is walked again
      translate(mk_va(8'h12, 8'h77, 10'h021), 1, "R7 fault not cached");
      // R8: fill remaining slots, then evict the oldest
      translate(mk_va(8'h12, 8'h35, 10'h001), 2, "R8 fill B");
      translate(mk_va(8'h13, 8'h00, 10'h002), 3, "R8 fill C");
      translate(mk_va(8'h13, 8'hFF, 10'h003), 1, "R8 fill D");
      translate(mk_va(8'h12, 8'h36, 10'h004), 1, "R8 fill E evicts A");
      translate(mk_va(8'h12, 8'h34, 10'h005), 2, "R8 A misses again");
      translate(mk_va(8'h13, 8'h00, 10'h006), 1, "R7 C still hits");
      translate(mk_va(8'h12, 8'h35, 10'h007), 1, "R8 B evicted");
      // R3: highest indices at both levels
      translate(mk_va(8'hFF, 8'hFF, 10'h3FF), 4, "R3 top indices");
      translate(mk_va(8'hFF, 8'hFF, 10'h200), 1, "R6 top indices hit");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule